// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable integer N and emits one output pulse per N input cycles. The division is built the way a frequency synthesiser's feedback path is built. A prescaler runs with a modulus of 33 or 32. A swallow count A selects how many prescaler cycles use the longer modulus. A main count B sets how many prescaler cycles make up one output period. The total ratio is N = 32·B + A. In this model the input clock stands in for the oscillator signal, and every counter runs on that one clock.

A new (A, B) pair arrives on a small valid/ready configuration stream. The block never applies back-pressure: `cfg_ready` is always high, so a word is taken on every cycle in which `cfg_valid` is high. The word is checked when it is accepted. A legal word waits in a pending slot until the current output period ends. An illegal word is refused and raises `cfg_err`.

Two plain control inputs stop the divider:
- `cnt_rst` clears the counters at once and holds them at their starting point.
- `pwr_dn` lets the current period finish and then parks the divider.

When both are high together, the divider parks at once and stays parked until `pwr_dn` falls.

Top module: `pswallow_fbdiv`

## Requirements
- R1: With a swallow value A and a main value B in force, the distance between consecutive `div_pulse` assertions is exactly 32·B + A input clock cycles.
- R2: Within each output period, the first A prescaler cycles last 33 input cycles and the remaining B − A cycles last 32. The prescaler count never passes 32, and never passes 31 while the short modulus is selected.
- R3: `div_pulse` is high for exactly one input clock cycle per period.
- R4: An accepted word with B < 3 or B ≤ A sets `cfg_err` on the following cycle and leaves the pending and active ratio unchanged. An accepted legal word clears `cfg_err` on the following cycle.
- R5: A legal word never changes the period in progress. The divider takes it up at the next period boundary, and the pending slot changes only on an accepted legal word. When several legal words arrive before a boundary, the last one wins.
- R6: While `cnt_rst` is high, both counters sit at zero and no pulse is produced. The first pulse after release appears N cycles after the first rising edge that samples `cnt_rst` low.
- R7: When `pwr_dn` rises with `cnt_rst` low, the period in progress completes and emits its pulse. After that, no pulse is produced while `pwr_dn` stays high. The first pulse after `pwr_dn` falls appears N + 1 cycles after the first edge that samples it low.
- R8: When `cnt_rst` and `pwr_dn` are high together, counting stops at once. The divider stays stopped after `cnt_rst` falls, for as long as `pwr_dn` stays high. It restarts as in R7.
- R9: `cfg_ready` is always high, and a word is accepted in any cycle, including while the divider is held or parked. A word accepted while the divider is held takes effect before counting resumes.
- R10: After reset, `div_pulse` and `cfg_err` are low. The ratio in force is A = 0, B = 31 (N = 992), so the first pulse comes 992 cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration word present |
| cfg_ready | output | 1 | Configuration word can be taken (always high) |
| cfg_swallow | input | 5 | Swallow value A |
| cfg_main | input | 10 | Main value B |
| cfg_err | output | 1 | The last accepted word was illegal |
| cnt_rst | input | 1 | Immediate counter clear and hold |
| pwr_dn | input | 1 | Park the divider at the end of the current period |
| div_pulse | output | 1 | One-cycle pulse per N input cycles |

## Verification
The hardest situations to reach from the ports are the handover points: a word landing near a period boundary, and a stop request arriving part-way through a period. The stimulus writes new ratios at arbitrary offsets inside a period and sends two words back to back before a boundary. It also writes a word while the divider is held. It raises `pwr_dn` mid-period, both alone and together with `cnt_rst`. A phase-counting model in the bench predicts every output cycle. Timed checks measure the gap across each handover. Ratios with A = 31 exercise the full run of long-modulus prescaler cycles, and a ratio of 32767 exercises the top of the main counter.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
  localparam int SW_W     = 5;
  localparam int MAIN_W   = 10;
  localparam int PRE_LOG  = 5;
  localparam int PRE_MOD  = 1 << PRE_LOG;
  localparam int PCNT_W   = PRE_LOG + 1;
  localparam int MAIN_MIN = 3;
  localparam int RATIO_W  = SW_W + MAIN_W;

  typedef struct packed {
    logic [SW_W-1:0]   a;
    logic [MAIN_W-1:0] b;
  } ratio_t;

  function automatic logic ratio_ok(ratio_t r);
    return (r.b >= MAIN_W'(MAIN_MIN)) &&
           (r.b > {{(MAIN_W-SW_W){1'b0}}, r.a});
  endfunction
endpackage

// File: rtl/pswallow_cfg.sv
module pswallow_cfg
  import pswallow_pkg::*;
#(
  parameter ratio_t RST_RATIO = '0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  ratio_t wr_ratio,
  input  logic   load,
  output ratio_t act,
  output ratio_t pend,
  output logic   err
);
  logic pend_vld;
  logic wr_good;

  assign wr_good = wr_en && ratio_ok(wr_ratio);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act      <= RST_RATIO;
      pend     <= RST_RATIO;
      pend_vld <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (load && pend_vld) act <= pend;
      if (wr_en) err <= !wr_good;
      if (wr_good) begin
        pend     <= wr_ratio;
        pend_vld <= 1'b1;
      end else if (load) begin
        pend_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler
  import pswallow_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              mod_hi,
  output logic              wrap,
  output logic [PCNT_W-1:0] cnt
);
  localparam logic [PCNT_W-1:0] TOP_LO = PCNT_W'(PRE_MOD - 1);
  localparam logic [PCNT_W-1:0] TOP_HI = PCNT_W'(PRE_MOD);

  assign wrap = (cnt == (mod_hi ? TOP_HI : TOP_LO));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr || wrap) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pswallow_mainctr.sv
module pswallow_mainctr
  import pswallow_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic [SW_W-1:0]   swallow,
  input  logic [MAIN_W-1:0] main_top,
  output logic              mod_hi,
  output logic              tc,
  output logic [MAIN_W-1:0] cnt
);
  assign mod_hi = ({{(MAIN_W-SW_W){1'b0}}, swallow} > cnt);
  assign tc     = (cnt == main_top - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (step)  cnt <= tc ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/pswallow_pwrseq.sv
module pswallow_pwrseq (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_rst,
  input  logic pwr_dn,
  input  logic period_end,
  output logic hold,
  output logic asleep
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) asleep <= 1'b0;
    else        asleep <= pwr_dn && (asleep || period_end || cnt_rst);
  end

  assign hold = cnt_rst || asleep;
endmodule

// File: rtl/pswallow_fbdiv.sv
module pswallow_fbdiv
  import pswallow_pkg::*;
#(
  parameter int RST_A = 0,
  parameter int RST_B = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [SW_W-1:0]   cfg_swallow,
  input  logic [MAIN_W-1:0] cfg_main,
  output logic              cfg_err,
  input  logic              cnt_rst,
  input  logic              pwr_dn,
  output logic              div_pulse
);
  localparam ratio_t RST_RATIO = '{a: SW_W'(RST_A), b: MAIN_W'(RST_B)};

  ratio_t              act;
  ratio_t              pend;
  ratio_t              wr_ratio;
  logic                wr_en;
  logic                hold;
  logic                asleep;
  logic                wrap;
  logic                tc;
  logic                mod_hi;
  logic                last;
  logic                load;
  logic [PCNT_W-1:0]   pcnt;
  logic [MAIN_W-1:0]   bcnt;

  assign cfg_ready = 1'b1;
  assign wr_en     = cfg_valid && cfg_ready;
  assign wr_ratio  = '{a: cfg_swallow, b: cfg_main};
  assign last      = !hold && wrap && tc;
  assign load      = hold || last;

  pswallow_cfg #(.RST_RATIO(RST_RATIO)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ratio(wr_ratio),
    .load(load), .act(act), .pend(pend), .err(cfg_err)
  );

  pswallow_pwrseq u_pwr (
    .clk(clk), .rst_n(rst_n), .cnt_rst(cnt_rst), .pwr_dn(pwr_dn),
    .period_end(last), .hold(hold), .asleep(asleep)
  );

  pswallow_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .clr(hold), .mod_hi(mod_hi),
    .wrap(wrap), .cnt(pcnt)
  );

  pswallow_mainctr u_main (
    .clk(clk), .rst_n(rst_n), .clr(hold), .step(wrap),
    .swallow(act.a), .main_top(act.b), .mod_hi(mod_hi), .tc(tc), .cnt(bcnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_pulse <= 1'b0;
    else        div_pulse <= last;
  end
endmodule

// File: rtl/pswallow_fbdiv_chk.sv
module pswallow_fbdiv_chk
  import pswallow_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               cnt_rst,
  input logic               pwr_dn,
  input logic               cfg_valid,
  input logic [SW_W-1:0]    cfg_swallow,
  input logic [MAIN_W-1:0]  cfg_main,
  input logic               cfg_err,
  input logic               div_pulse,
  input logic [PCNT_W-1:0]  pcnt,
  input logic [MAIN_W-1:0]  bcnt,
  input logic               mod_hi,
  input logic               wrap,
  input logic               hold,
  input logic               last,
  input logic [RATIO_W-1:0] act,
  input logic [RATIO_W-1:0] pend
);
  logic bad_word;
  assign bad_word = (cfg_main < MAIN_W'(MAIN_MIN)) ||
                    (cfg_main <= {{(MAIN_W-SW_W){1'b0}}, cfg_swallow});

  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  // R2
  presc_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_hi |-> (pcnt <= PCNT_W'(PRE_MOD - 1)));

  // R2
  mod_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wrap) && !$past(hold)) |-> $stable(mod_hi));

  // R5
  act_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act != $past(act)) |-> $past(last || hold));

  // R4
  bad_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && bad_word) |=> (cfg_err && $stable(pend)));

  // R6
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |=> (pcnt == '0 && bcnt == '0 && !div_pulse));

  // R8
  park_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_rst && pwr_dn) && pwr_dn) |-> (pcnt == '0 && !div_pulse));
endmodule

bind pswallow_fbdiv pswallow_fbdiv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_rst(cnt_rst), .pwr_dn(pwr_dn),
  .cfg_valid(cfg_valid), .cfg_swallow(cfg_swallow), .cfg_main(cfg_main),
  .cfg_err(cfg_err), .div_pulse(div_pulse), .pcnt(pcnt), .bcnt(bcnt),
  .mod_hi(mod_hi), .wrap(wrap), .hold(hold), .last(last),
  .act(act), .pend(pend)
);

// File: tb/pswallow_fbdiv_tb.sv
`timescale 1ns/1ps
module pswallow_fbdiv_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_valid = 1'b0;
  logic       cfg_ready;
  logic [4:0] cfg_swallow = '0;
  logic [9:0] cfg_main = '0;
  logic       cfg_err;
  logic       cnt_rst = 1'b0;
  logic       pwr_dn = 1'b0;
  logic       div_pulse;

  always #2.5 clk = ~clk;

  pswallow_fbdiv u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_swallow(cfg_swallow), .cfg_main(cfg_main), .cfg_err(cfg_err),
    .cnt_rst(cnt_rst), .pwr_dn(pwr_dn), .div_pulse(div_pulse)
  );

  int    checks = 0;
  int    fails = 0;
  longint cyc = 0;
  bit    finished = 0;
  longint last_p = 0;

  // reference model state
  int m_a, m_b, p_a, p_b, m_ph;
  bit m_pvld, m_pulse, m_err, m_asleep;

  function automatic int ratio_n(int a, int b);
    return 32 * b + a;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_a = 0; m_b = 31; p_a = 0; p_b = 31; m_pvld = 0;
      m_ph = 0; m_pulse = 0; m_err = 0; m_asleep = 0;
    end else begin
      bit run, endp, ld, nsleep, good;
      run    = !cnt_rst && !m_asleep;
      endp   = run && (m_ph == ratio_n(m_a, m_b) - 1);
      nsleep = pwr_dn && (m_asleep || endp || cnt_rst);
      ld     = !run || endp;
      if (!run) begin m_ph = 0; m_pulse = 0; end
      else if (endp) begin m_ph = 0; m_pulse = 1; end
      else begin m_ph++; m_pulse = 0; end
      if (ld) begin
        if (m_pvld) begin m_a = p_a; m_b = p_b; end
        m_pvld = 0;
      end
      if (cfg_valid) begin
        good  = (int'(cfg_main) >= 3) && (int'(cfg_main) > int'(cfg_swallow));
        m_err = !good;
        if (good) begin p_a = cfg_swallow; p_b = cfg_main; m_pvld = 1; end
      end
      m_asleep = nsleep;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(div_pulse == m_pulse, "R1/R3 div_pulse vs model", div_pulse, m_pulse);
      chk(cfg_err == m_err, "R4 cfg_err vs model", cfg_err, m_err);
    end
  end

  always @(posedge clk) begin
    if (cyc > 195000 && !finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<195000", cyc);
      finish_run();
    end
  end

  task automatic write_cfg(int a, int b);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_swallow = 5'(a); cfg_main = 10'(b);
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic wait_pulse(output longint at);
    @(negedge clk);
    while (!div_pulse) @(negedge clk);
    at = cyc;
  endtask

  task automatic reprogram(int a, int b, int old_n, string tag);
    longint pa, pb;
    write_cfg(a, b);
    wait_pulse(pa);
    chk(pa - last_p == old_n, "R5 period in progress keeps old ratio", pa - last_p, old_n);
    wait_pulse(pb);
    chk(pb - pa == ratio_n(a, b), tag, pb - pa, ratio_n(a, b));
    last_p = pb;
  endtask

  task automatic count_pulses(int cycles, output int n);
    n = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (div_pulse) n++;
    end
  endtask

  initial begin
    longint rel, pa, pb;
    int n;
    repeat (4) @(negedge clk);
    // R10 reset state, R9 ready
    chk(div_pulse == 1'b0, "R10 div_pulse in reset", div_pulse, 0);
    chk(cfg_err == 1'b0, "R10 cfg_err in reset", cfg_err, 0);
    chk(cfg_ready == 1'b1, "R9 cfg_ready high", cfg_ready, 1);
    rst_n = 1'b1;
    rel = cyc;
    wait_pulse(pa);
    chk(pa - rel == 992, "R10 first pulse after reset", pa - rel, 992);
    wait_pulse(pb);
    chk(pb - pa == 992, "R1 default ratio gap", pb - pa, 992);
    last_p = pb;

    repeat (37) @(negedge clk);
    reprogram(2, 3, 992, "R1 ratio A=2 B=3");
    reprogram(0, 4, 98, "R1 ratio A=0 B=4");
    reprogram(31, 40, 128, "R2 ratio A=31 B=40");
    reprogram(31, 1023, 1311, "R2 ratio A=31 B=1023");
    reprogram(0, 4, 32767, "R1 ratio back to A=0 B=4");

    // R4 illegal words
    write_cfg(3, 3);
    chk(cfg_err == 1'b1, "R4 B equal to A flagged", cfg_err, 1);
    write_cfg(0, 2);
    chk(cfg_err == 1'b1, "R4 B below 3 flagged", cfg_err, 1);
    wait_pulse(pa);
    wait_pulse(pb);
    chk(pb - pa == 128, "R4 illegal words leave ratio", pb - pa, 128);
    last_p = pb;
    write_cfg(1, 5);
    chk(cfg_err == 1'b0, "R4 legal word clears flag", cfg_err, 0);
    wait_pulse(pa);
    chk(pa - last_p == 128, "R5 old ratio until boundary", pa - last_p, 128);
    wait_pulse(pb);
    chk(pb - pa == 161, "R1 ratio A=1 B=5", pb - pa, 161);
    last_p = pb;

    // R5 last of two words wins
    write_cfg(0, 4);
    write_cfg(3, 4);
    wait_pulse(pa);
    chk(pa - last_p == 161, "R5 boundary after two words", pa - last_p, 161);
    wait_pulse(pb);
    chk(pb - pa == 131, "R5 last word wins", pb - pa, 131);
    last_p = pb;

    // R6 hold with R9 write during hold
    repeat (20) @(negedge clk);
    cnt_rst = 1'b1;
    write_cfg(0, 4);
    count_pulses(300, n);
    chk(n == 0, "R6 no pulse while held", n, 0);
    cnt_rst = 1'b0;
    rel = cyc;
    wait_pulse(pa);
    chk(pa - rel == 128, "R6/R9 restart with word written during hold", pa - rel, 128);
    last_p = pa;

    // R7 graceful power-down
    repeat (30) @(negedge clk);
    pwr_dn = 1'b1;
    wait_pulse(pa);
    chk(pa - last_p == 128, "R7 current period completes", pa - last_p, 128);
    count_pulses(400, n);
    chk(n == 0, "R7 parked after period", n, 0);
    pwr_dn = 1'b0;
    rel = cyc;
    wait_pulse(pb);
    chk(pb - rel == 129, "R7 restart after wake", pb - rel, 129);
    last_p = pb;

    // R8 immediate power-down
    repeat (30) @(negedge clk);
    cnt_rst = 1'b1;
    pwr_dn = 1'b1;
    repeat (2) @(negedge clk);
    cnt_rst = 1'b0;
    count_pulses(400, n);
    chk(n == 0, "R8 stays parked after clear falls", n, 0);
    pwr_dn = 1'b0;
    rel = cyc;
    wait_pulse(pb);
    chk(pb - rel == 129, "R8 restart after wake", pb - rel, 129);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule